// File: doc/BRIEF.md
# Phased Serial Audio Transmitter

This block takes parallel audio words from a valid/ready port and shifts them out on one serial data line, most significant bit first. An external master supplies the bit clock and the frame sync; the block watches both as ordinary synchronous inputs and does not generate either. A frame has one or two phases. Each phase has its own word count and word length, so a stereo pair can go out as a left phase and a right phase of one word each, and a multi-slot time-division frame fits in a single phase.

Configuration inputs select the word length of each phase, the word count of each phase, single or dual phase, a data delay of zero or one bit clock after the frame-sync edge, the bit-clock edge on which data changes and the active level of frame sync. These inputs are expected to stay constant while a frame is in progress. When a word slot begins and no input word is waiting, the block raises a one-cycle underrun pulse and sends zeros in that slot.

Top module: `phased_audio_tx`

## Requirements
- R1: The word-length code of each phase selects bits per word as 0→8, 1→12, 2→16, 3→20, 4→24, 5→32; codes 6 and 7 also select 32.
- R2: Each word is sent most significant bit first, and only its low word-length bits are sent; input bits above the word length have no effect on the line.
- R3: A phase word-count field holds the number of words minus one. In dual-phase mode (`cfg_dual_i`=1) all phase-0 words are sent, then all phase-1 words, each phase with its own word length.
- R4: In single-phase mode (`cfg_dual_i`=0) a frame holds only the phase-0 words; phase-1 settings have no effect.
- R5: A new frame starts at a drive edge where frame sync has just become active. With `cfg_delay_i`=0 the first data bit appears at that same drive edge; with `cfg_delay_i`=1 it appears one drive edge later.
- R6: With `cfg_bclk_rise_i`=0 the drive edge is the falling bit-clock edge; with 1 it is the rising edge. `sd_o` changes only in the clock cycle after a drive edge is seen.
- R7: With `cfg_fs_low_i`=0 frame sync is active high; with 1 it is active low.
- R8: Between the last bit of a frame and the first bit of the next, `sd_o` is low.
- R9: A frame-sync activation while a frame still has bits to send is ignored; an activation that arrives just as the previous frame finishes (the bit clock where its last bit is driven for delay 1, the next one for delay 0) starts the next frame with no gap.
- R10: `in_ready_o` is high for exactly one clock cycle at the start of each word slot; the word on `in_data_i` is taken in that cycle when `in_valid_i` is high.
- R11: When a word slot starts with `in_valid_i` low, `underrun_o` pulses for one cycle and the slot sends all zeros.
- R12: After reset `sd_o`, `in_ready_o` and `underrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bit clock and frame sync are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_i | input | 1 | Bit clock level, synchronous to `clk` and slower than half its rate |
| fsync_i | input | 1 | Frame sync level, synchronous to `clk` |
| cfg_wlen0_i | input | 3 | Word-length code of phase 0 |
| cfg_wlen1_i | input | 3 | Word-length code of phase 1 |
| cfg_wcnt0_i | input | WCNT_W | Phase-0 word count minus one |
| cfg_wcnt1_i | input | WCNT_W | Phase-1 word count minus one |
| cfg_dual_i | input | 1 | 1 selects dual-phase frames |
| cfg_delay_i | input | 1 | Data delay in bit clocks after the frame-sync edge (0 or 1) |
| cfg_bclk_rise_i | input | 1 | 1 makes the rising bit-clock edge the drive edge |
| cfg_fs_low_i | input | 1 | 1 makes frame sync active low |
| in_valid_i | input | 1 | Input word is valid |
| in_data_i | input | 32 | Input word, right-aligned |
| in_ready_o | output | 1 | Word slot starting; word taken when valid |
| sd_o | output | 1 | Serial data line |
| underrun_o | output | 1 | One-cycle pulse: slot started without a valid word |

## Verification
The bench builds the block with a 3-bit word-count field, which keeps frames short enough to sweep every word-length code in both phase modes and with both delays, while cycling through all four combinations of clock and frame-sync polarity. Short fields also make back-to-back streams practical, so the restart at the final bit for delay 1 and at the end edge for delay 0 is exercised with three consecutive frames each. Every frame carries a second frame-sync pulse inside its data, and input words carry set bits above the word length, so the ignore and masking rules show up directly in the captured bit stream.

// File: rtl/ptx_pkg.sv
// Shared constants and helpers for the phased serial audio transmitter.
// Assumes the widest supported word is 32 bits.
package ptx_pkg;
    localparam int unsigned WORD_MAX = 32;
    localparam int unsigned LEN_W    = 6;

    typedef logic [LEN_W-1:0] len_t;

    // Translate a 3-bit word-length code into bits per word.
    function automatic len_t code_to_len(input logic [2:0] code);
        case (code)
            3'd0:    return len_t'(8);
            3'd1:    return len_t'(12);
            3'd2:    return len_t'(16);
            3'd3:    return len_t'(20);
            3'd4:    return len_t'(24);
            default: return len_t'(32);
        endcase
    endfunction
endpackage

// File: rtl/ptx_edge_det.sv
// Bit-clock drive-edge and frame-sync activation detector.
// Assumes bclk_i and fsync_i are already synchronous to clk and that the
// bit clock holds each level for at least one clk cycle.
module ptx_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fsync_i,
    input  logic cfg_bclk_rise_i,
    input  logic cfg_fs_low_i,
    output logic drive_edge_o,
    output logic fs_start_o
);
    logic bclk_q;
    logic fs_prev_q;
    logic fs_act;

    // Frame sync normalised to active high.
    assign fs_act = fsync_i ^ cfg_fs_low_i;

    // A drive edge is a bit-clock transition towards the selected level.
    assign drive_edge_o = (bclk_i != bclk_q) && (bclk_i == cfg_bclk_rise_i);

    // Frame starts only on an inactive-to-active change seen at drive edges.
    assign fs_start_o = drive_edge_o && fs_act && !fs_prev_q;

    // Track previous bit-clock level and frame-sync level at drive edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q    <= bclk_i;
            fs_prev_q <= 1'b0;
        end else begin
            bclk_q <= bclk_i;
            if (drive_edge_o) begin
                fs_prev_q <= fs_act;
            end
        end
    end
endmodule

// File: rtl/ptx_frame_seq.sv
// Frame sequencer: counts bits, words and phases of one frame and decides
// when word slots start, when the shift register advances and when the
// line returns low. Assumes configuration is stable during a frame.
module ptx_frame_seq
    import ptx_pkg::*;
#(
    parameter int unsigned WCNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_edge_i,
    input  logic              fs_start_i,
    input  logic [2:0]        cfg_wlen0_i,
    input  logic [2:0]        cfg_wlen1_i,
    input  logic [WCNT_W-1:0] cfg_wcnt0_i,
    input  logic [WCNT_W-1:0] cfg_wcnt1_i,
    input  logic              cfg_dual_i,
    input  logic              cfg_delay_i,
    output logic              slot_start_o,
    output len_t              slot_len_o,
    output logic              shift_o,
    output logic              clear_o,
    output logic              busy_o
);
    logic              busy_q;
    logic              pend_q;
    logic              phase_q;
    logic [WCNT_W-1:0] word_q;
    len_t              bit_q;

    len_t              len0;
    len_t              len1;
    len_t              cur_len;
    logic [WCNT_W-1:0] cur_cnt;
    logic              last_word;
    logic              at_last;
    logic              penult;
    logic              free;
    logic              start_first;
    logic              advance;
    logic              word_end;
    logic              next_word;
    logic              to_ph1;
    logic              frame_end;
    logic              arm;

    // Per-phase lengths and the settings of the phase in progress.
    always_comb begin
        len0    = code_to_len(cfg_wlen0_i);
        len1    = code_to_len(cfg_wlen1_i);
        cur_len = phase_q ? len1 : len0;
        cur_cnt = phase_q ? cfg_wcnt1_i : cfg_wcnt0_i;
    end

    // Position flags and the actions taken at this drive edge.
    always_comb begin
        last_word   = (word_q == cur_cnt) && (phase_q || !cfg_dual_i);
        at_last     = busy_q && last_word && (bit_q == '0);
        penult      = busy_q && last_word && (bit_q == len_t'(1));
        free        = !busy_q || at_last;
        start_first = drive_edge_i && free &&
                      (pend_q || (fs_start_i && !cfg_delay_i));
        advance     = drive_edge_i && busy_q && !start_first;
        word_end    = (bit_q == '0);
        next_word   = advance && word_end && !last_word;
        to_ph1      = (word_q == cur_cnt);
        frame_end   = advance && at_last;
        arm         = drive_edge_i && !start_first && !pend_q && fs_start_i &&
                      cfg_delay_i && (free || penult);
        slot_start_o = start_first || next_word;
        slot_len_o   = start_first ? len0 : (to_ph1 ? len1 : cur_len);
        shift_o      = advance && !word_end;
        clear_o      = frame_end;
        busy_o       = busy_q;
    end

    // Bit, word and phase counters plus the delayed-start flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            pend_q  <= 1'b0;
            phase_q <= 1'b0;
            word_q  <= '0;
            bit_q   <= '0;
        end else if (start_first) begin
            busy_q  <= 1'b1;
            pend_q  <= 1'b0;
            phase_q <= 1'b0;
            word_q  <= '0;
            bit_q   <= len0 - len_t'(1);
        end else begin
            if (next_word) begin
                if (to_ph1) begin
                    phase_q <= 1'b1;
                    word_q  <= '0;
                end else begin
                    word_q <= word_q + WCNT_W'(1);
                end
                bit_q <= slot_len_o - len_t'(1);
            end else if (shift_o) begin
                bit_q <= bit_q - len_t'(1);
            end else if (frame_end) begin
                busy_q <= 1'b0;
            end
            if (arm) begin
                pend_q <= 1'b1;
            end
        end
    end

    AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (bit_q < cur_len)); // R1

    AST_PEND_NEEDS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(cfg_delay_i)); // R5
endmodule

// File: rtl/ptx_shifter.sv
// Output shift register: loads a word MSB-aligned at each slot start (or
// zeros when no word is valid), shifts left at each drive edge inside the
// word and clears at frame end. Also produces the underrun pulse.
module ptx_shifter
    import ptx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_start_i,
    input  len_t                slot_len_i,
    input  logic                shift_i,
    input  logic                clear_i,
    input  logic                in_valid_i,
    input  logic [WORD_MAX-1:0] in_data_i,
    output logic                sd_o,
    output logic                underrun_o
);
    logic [WORD_MAX-1:0] shreg_q;
    len_t                shamt;

    // Left shift that drops bits above the word length and aligns the MSB.
    assign shamt = len_t'(WORD_MAX) - slot_len_i;
    assign sd_o  = shreg_q[WORD_MAX-1];

    // Load, shift or clear the outgoing word; flag a slot with no data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            underrun_o <= 1'b0;
        end else begin
            underrun_o <= slot_start_i && !in_valid_i;
            if (slot_start_i) begin
                shreg_q <= in_valid_i ? (in_data_i << shamt) : '0;
            end else if (shift_i) begin
                shreg_q <= shreg_q << 1;
            end else if (clear_i) begin
                shreg_q <= '0;
            end
        end
    end

    AST_UNDERRUN_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> (shreg_q == '0)); // R11

    AST_UNDERRUN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> !underrun_o); // R11
endmodule

// File: rtl/phased_audio_tx.sv
// Phased serial audio transmitter top. Detects bit-clock drive edges and
// frame-sync activations, sequences one- or two-phase frames and shifts
// words out MSB first. Assumes the bit clock runs below half the clk rate
// and configuration changes only between frames.
module phased_audio_tx
    import ptx_pkg::*;
#(
    parameter int unsigned WCNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic [2:0]        cfg_wlen0_i,
    input  logic [2:0]        cfg_wlen1_i,
    input  logic [WCNT_W-1:0] cfg_wcnt0_i,
    input  logic [WCNT_W-1:0] cfg_wcnt1_i,
    input  logic              cfg_dual_i,
    input  logic              cfg_delay_i,
    input  logic              cfg_bclk_rise_i,
    input  logic              cfg_fs_low_i,
    input  logic              in_valid_i,
    input  logic [31:0]       in_data_i,
    output logic              in_ready_o,
    output logic              sd_o,
    output logic              underrun_o
);
    logic drive_edge;
    logic fs_start;
    logic slot_start;
    len_t slot_len;
    logic shift_en;
    logic clear_en;
    logic frame_busy;

    ptx_edge_det u_edge (
        .clk             (clk),
        .rst_n           (rst_n),
        .bclk_i          (bclk_i),
        .fsync_i         (fsync_i),
        .cfg_bclk_rise_i (cfg_bclk_rise_i),
        .cfg_fs_low_i    (cfg_fs_low_i),
        .drive_edge_o    (drive_edge),
        .fs_start_o      (fs_start)
    );

    ptx_frame_seq #(.WCNT_W(WCNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .drive_edge_i (drive_edge),
        .fs_start_i   (fs_start),
        .cfg_wlen0_i  (cfg_wlen0_i),
        .cfg_wlen1_i  (cfg_wlen1_i),
        .cfg_wcnt0_i  (cfg_wcnt0_i),
        .cfg_wcnt1_i  (cfg_wcnt1_i),
        .cfg_dual_i   (cfg_dual_i),
        .cfg_delay_i  (cfg_delay_i),
        .slot_start_o (slot_start),
        .slot_len_o   (slot_len),
        .shift_o      (shift_en),
        .clear_o      (clear_en),
        .busy_o       (frame_busy)
    );

    ptx_shifter u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_start_i (slot_start),
        .slot_len_i   (slot_len),
        .shift_i      (shift_en),
        .clear_i      (clear_en),
        .in_valid_i   (in_valid_i),
        .in_data_i    (in_data_i),
        .sd_o         (sd_o),
        .underrun_o   (underrun_o)
    );

    // Ready is offered exactly when a word slot begins.
    assign in_ready_o = slot_start;

    AST_SD_QUIET_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(drive_edge) |-> $stable(sd_o)); // R6

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_busy |-> !sd_o); // R8

    AST_READY_ON_DRIVE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> drive_edge); // R10
endmodule

// File: tb/phased_audio_tx_tb_top.sv
module phased_audio_tx_tb_top;
    localparam int WCW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bclk = 1'b1;
    logic           fsync = 1'b0;
    logic [2:0]     wl0 = 3'd2, wl1 = 3'd2;
    logic [WCW-1:0] wc0 = '0, wc1 = '0;
    logic           dual = 1'b0, dly = 1'b0, rise = 1'b0, fsl = 1'b0;
    logic           in_valid = 1'b1;
    logic [31:0]    in_data;
    logic           in_ready, sd, underrun;

    int checks = 0;
    int errors = 0;
    int feed_k = 0;
    int exp_k  = 0;
    int urun_cnt = 0;
    bit done = 1'b0;
    logic got [0:1023];

    always #4 clk = ~clk;

    phased_audio_tx #(.WCNT_W(WCW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync),
        .cfg_wlen0_i(wl0), .cfg_wlen1_i(wl1), .cfg_wcnt0_i(wc0), .cfg_wcnt1_i(wc1),
        .cfg_dual_i(dual), .cfg_delay_i(dly), .cfg_bclk_rise_i(rise), .cfg_fs_low_i(fsl),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
        .sd_o(sd), .underrun_o(underrun)
    );

    function automatic logic [31:0] word_val(input int k);
        return (32'(k) * 32'h9E3779B9) ^ 32'hF5A5C3C3;
    endfunction

    function automatic int len_of(input int code);
        case (code)
            0: return 8;  1: return 12; 2: return 16;
            3: return 20; 4: return 24; default: return 32;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bit-clock period: drive edge, sample one cycle later, opposite edge.
    task automatic bit_period(input bit fs_on, output logic b);
        @(negedge clk);
        bclk  = rise;
        fsync = fs_on ^ fsl;
        @(negedge clk);
        b = sd;
        @(negedge clk);
        bclk = ~rise;
        @(negedge clk);
    endtask

    // Accepts the offered word and presents the next one.
    initial begin
        in_data = word_val(0);
        forever begin
            @(negedge clk);
            #1;
            if (in_valid && in_ready) begin
                @(posedge clk);
                #1;
                feed_k++;
                in_data = word_val(feed_k);
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (underrun) urun_cnt++;
        end
    end

    task automatic set_cfg(input int c0, input int c1, input int n0, input int n1,
                           input int du, input int dl, input int pol);
        @(negedge clk);
        wl0 = 3'(c0); wl1 = 3'(c1); wc0 = WCW'(n0); wc1 = WCW'(n1);
        dual = du[0]; dly = dl[0]; rise = pol[0]; fsl = pol[1];
        bclk = ~rise; fsync = fsl;
        repeat (3) @(negedge clk);
    endtask

    // Sends nfr frames spaced by bits+gap periods and checks every word slot.
    task automatic run_stream(input int nfr, input int gap, input string tag);
        int l0, l1, n0, n1, bits, per, total, acc0, ur0, pos;
        bit covered [0:1023];
        logic b;
        l0 = len_of(int'(wl0)); l1 = len_of(int'(wl1));
        n0 = int'(wc0) + 1; n1 = dual ? int'(wc1) + 1 : 0;
        bits = n0 * l0 + n1 * l1;
        per = bits + gap;
        total = nfr * per + 4;
        acc0 = feed_k; ur0 = urun_cnt;
        for (int i = 0; i < 1024; i++) covered[i] = 1'b0;
        for (int p = 0; p < total; p++) begin
            int off;
            off = p % per;
            bit_period((p < nfr * per) && (off == 0 || off == 3), b);
            got[p] = b;
        end
        for (int f = 0; f < nfr; f++) begin
            pos = f * per + int'(dly);
            for (int ph = 0; ph < 2; ph++) begin
                int nw, wl;
                nw = (ph == 0) ? n0 : n1;
                wl = (ph == 0) ? l0 : l1;
                for (int w = 0; w < nw; w++) begin
                    logic [31:0] act, exp, msk;
                    msk = (wl == 32) ? 32'hFFFF_FFFF : ((32'h1 << wl) - 32'h1);
                    exp = in_valid ? (word_val(exp_k) & msk) : 32'h0;
                    if (in_valid) exp_k++;
                    act = '0;
                    for (int bi = 0; bi < wl; bi++) begin
                        act = {act[30:0], got[pos]};
                        covered[pos] = 1'b1;
                        pos++;
                    end
                    // R1 R2 R3 R4 R5 R7 R9: slot content and position
                    chk(act == exp, {tag, " R2/R3 slot"}, act, exp);
                end
            end
        end
        begin
            int ones;
            ones = 0;
            for (int p = 0; p < total; p++) if (!covered[p] && got[p]) ones++;
            chk(ones == 0, {tag, " R8 idle low"}, 32'(ones), 32'h0);
        end
        if (in_valid) begin
            chk(feed_k - acc0 == nfr * (n0 + n1), {tag, " R10 accepts"}, 32'(feed_k - acc0), 32'(nfr * (n0 + n1)));
            chk(urun_cnt == ur0, {tag, " R11 no underrun"}, 32'(urun_cnt - ur0), 32'h0);
        end else begin
            chk(feed_k == acc0, {tag, " R10 no accept"}, 32'(feed_k - acc0), 32'h0);
            chk(urun_cnt - ur0 == nfr * (n0 + n1), {tag, " R11 underruns"}, 32'(urun_cnt - ur0), 32'(nfr * (n0 + n1)));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(sd == 1'b0, "R12 sd", 32'(sd), 32'h0);
        chk(in_ready == 1'b0, "R12 ready", 32'(in_ready), 32'h0);
        chk(underrun == 1'b0, "R12 underrun", 32'(underrun), 32'h0);

        // R1 R3 R4 R5 R6 R7: sweep codes, phase modes, delays, polarities
        for (int c = 0; c < 6; c++)
            for (int du = 0; du < 2; du++)
                for (int dl = 0; dl < 2; dl++) begin
                    set_cfg(c, (c + 3) % 6, c % 2, (c + dl) % 2, du, dl, (c * 4 + du * 2 + dl) % 4);
                    run_stream(1, 3, "sweep");
                end
        // R1: codes 6 and 7 behave as 32 bits
        set_cfg(6, 7, 0, 0, 1, 1, 0);
        run_stream(1, 3, "R1 code6/7");

        // R9: back-to-back stereo frames, delay 1 and delay 0
        set_cfg(2, 2, 0, 0, 1, 1, 2);
        run_stream(3, 0, "R9 b2b d1");
        set_cfg(5, 5, 0, 0, 1, 0, 1);
        run_stream(3, 0, "R9 b2b d0");
        set_cfg(3, 0, 1, 1, 0, 0, 3);
        run_stream(3, 0, "R9 b2b tdm");

        // R11: no input words available
        set_cfg(1, 0, 2, 0, 0, 1, 0);
        in_valid = 1'b0;
        run_stream(1, 3, "R11 starve");
        in_valid = 1'b1;
        set_cfg(0, 4, 1, 0, 1, 0, 0);
        run_stream(2, 2, "recover");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule